// File: doc/BRIEF.md
# Addressable LED Pulse Encoder

This block turns a stream of colour bytes into the single-wire waveform that a chain of addressable RGB LEDs expects. Bytes arrive over a valid/ready interface, three per LED in green, red, blue order, and the block passes them on unchanged. A start marker opens a frame and an end marker closes it. Every data bit becomes eight equal output slots, sent like a serial shift register. Each slot lasts a whole number of system clock cycles, set by a divider. A zero bit is two high slots and then six low ones. A one bit is four high slots and then four low ones. With a 24 MHz clock and a divider of 4, a slot is about 166 ns. A zero is then about 330 ns high and 1 µs low, and a one is about 660 ns high and 660 ns low.

The block pulls the next byte only in the last clock cycle of the current one. This keeps consecutive bits back to back with no idle slots, so a frame of N LEDs takes exactly N×3×64 slots. When the frame ends, the line stays low for a set latch interval, during which the block refuses new input. If the source has no byte ready when one is needed mid-frame, the block stops at the byte boundary, where the line is already low. It flags the underrun and then runs the same latch interval.

Top module: `led_chain_encoder`

## Requirements
- R1: During and after a synchronous active-high reset, line_out and busy and underrun are 0, and in_ready is 1.
- R2: While idle, a byte offered without in_first set is consumed and dropped: busy and line_out stay 0.
- R3: A bit of value 0 drives line_out high for 2×CLK_DIV cycles, then low for 6×CLK_DIV cycles. A bit of value 1 drives it high for 4×CLK_DIV cycles, then low for 4×CLK_DIV cycles. The first slot begins in the cycle after the byte is accepted.
- R4: Bits of each byte go out most significant first, and the bytes go out in the order they were accepted, with no reordering of colour bytes.
- R5: While sending a byte that is not the frame's last, in_ready is 1 only in the final clock cycle of that byte. A byte accepted there starts its first slot in the very next cycle, with no gap.
- R6: An in_first flag on a byte that arrives in the middle of a frame has no effect; the byte is sent as ordinary data.
- R7: After the byte flagged in_last ends, line_out is 0 and in_ready is 0 for LATCH_SLOTS×CLK_DIV cycles. After that the block is idle and ready.
- R8: If in_valid is 0 in the cycle a mid-frame byte ends, underrun becomes 1 and line_out stays low, and the latch interval follows. underrun stays 1 until the start byte of a new frame is accepted, which clears it.
- R9: busy is 1 from the cycle after a start byte is accepted until the latch interval ends, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | 8 | Colour byte, green/red/blue order per LED |
| in_first | input | 1 | Byte opens a frame |
| in_last | input | 1 | Byte closes a frame |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| line_out | output | 1 | Serial waveform to the LED chain, idles low |
| busy | output | 1 | Frame or latch interval in progress |
| underrun | output | 1 | Source ran dry inside the current or last frame |

## Verification
The bench goes after four kinds of fault.

- **Byte hand-off.** The source keeps valid high, so each new byte has to start in the cycle right after the old one ends. A design that asks for data early or late would drop a slot or insert idle time, and the reference would see a shifted waveform.
- **Frame markers.** A stray byte without a start marker is offered while idle, and another start marker is planted mid-frame. A design that opened a frame on the stray byte, or restarted on the planted marker, would produce extra or missing bytes. The bench decodes the high-pulse widths back into bytes to catch this.
- **Latch interval.** A second frame is queued behind a finished one. It must wait out the whole interval, so a short or long latch shows up on in_ready and busy.
- **Underrun.** A frame is starved partway through. A design that kept shifting would emit a truncated or stale pulse. A design that forgot to clear the flag on the next frame would show underrun stuck high.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

   localparam int BYTE_W        = 8;
   localparam int SLOTS_PER_BIT = 8;
   localparam int IDX_W         = $clog2(SLOTS_PER_BIT);

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SEND  = 2'd1,
      ST_LATCH = 2'd2
   } enc_state_t;

endpackage

// File: rtl/led_slot_divider.sv
module led_slot_divider #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);

   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   generate
      if (CLK_DIV == 1) begin : g_pass
         assign tick = run;
      end else begin : g_count
         logic [DIV_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || !run) begin
               cnt_q <= '0;
            end else if (cnt_q == DIV_W'(CLK_DIV - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = run && (cnt_q == DIV_W'(CLK_DIV - 1));

         // slots longer than one cycle never tick on two adjacent cycles
         assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/led_bit_shifter.sv
module led_bit_shifter
   import led_enc_pkg::*;
#(
   parameter logic [BYTE_W-1:0] ZERO_PAT = 8'hC0,
   parameter logic [BYTE_W-1:0] ONE_PAT  = 8'hF0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              tick,
   output logic              bit_out,
   output logic              at_byte_end
);

   localparam int BIT_W = $clog2(BYTE_W);
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS_PER_BIT - 1);

   logic [BYTE_W-1:0]        data_q;
   logic [BIT_W-1:0]         bit_idx_q;
   logic [IDX_W-1:0]         slot_idx_q;
   logic [SLOTS_PER_BIT-1:0] pat_q;

   function automatic logic [SLOTS_PER_BIT-1:0] pick_pattern(input logic b);
      return b ? ONE_PAT : ZERO_PAT;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q     <= '0;
         bit_idx_q  <= '0;
         slot_idx_q <= '0;
         pat_q      <= '0;
      end else if (load) begin
         data_q     <= load_byte;
         bit_idx_q  <= BIT_W'(BYTE_W - 1);
         slot_idx_q <= '0;
         pat_q      <= pick_pattern(load_byte[BYTE_W-1]);
      end else if (tick) begin
         if (slot_idx_q == LAST_SLOT) begin
            slot_idx_q <= '0;
            if (bit_idx_q != '0) begin
               bit_idx_q <= bit_idx_q - 1'b1;
               pat_q     <= pick_pattern(data_q[bit_idx_q - 1'b1]);
            end else begin
               pat_q     <= '0;
            end
         end else begin
            slot_idx_q <= slot_idx_q + 1'b1;
            pat_q      <= {pat_q[SLOTS_PER_BIT-2:0], 1'b0};
         end
      end
   end

   assign bit_out     = pat_q[SLOTS_PER_BIT-1];
   assign at_byte_end = (slot_idx_q == LAST_SLOT) && (bit_idx_q == '0);

   // each bit opens with a high slot
   assert_bit_starts_high_R3: assert property (@(posedge clk) disable iff (rst)
      load |=> bit_out);

   // each bit closes with a low slot, so a byte boundary is always low
   assert_bit_ends_low_R3: assert property (@(posedge clk) disable iff (rst)
      (slot_idx_q == LAST_SLOT) |-> !bit_out);

   // the slot position only moves on a divided tick or a load
   assert_slot_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!load && !tick) |=> $stable(slot_idx_q));

endmodule

// File: rtl/led_latch_timer.sv
module led_latch_timer #(
   parameter int LATCH_CYC = 1280
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic done
);

   localparam int LAT_W = $clog2(LATCH_CYC + 1);
   localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LATCH_CYC - 1);

   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
      end else if (cnt_q != LAT_LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = run && (cnt_q == LAT_LAST);

   // the owner leaves the latch phase as soon as the interval has elapsed
   assert_latch_single_done_R7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

endmodule

// File: rtl/led_chain_encoder.sv
module led_chain_encoder
   import led_enc_pkg::*;
#(
   parameter int                CLK_DIV     = 4,
   parameter int                LATCH_SLOTS = 320,
   parameter logic [BYTE_W-1:0] ZERO_PAT    = 8'hC0,
   parameter logic [BYTE_W-1:0] ONE_PAT     = 8'hF0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_first,
   input  logic              in_last,
   output logic              in_ready,
   output logic              line_out,
   output logic              busy,
   output logic              underrun
);

   localparam int LATCH_CYC = LATCH_SLOTS * CLK_DIV;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (LATCH_SLOTS < 1) begin : g_bad_latch
         $error("LATCH_SLOTS must be at least 1");
      end
      if (!ZERO_PAT[BYTE_W-1] || !ONE_PAT[BYTE_W-1]) begin : g_bad_lead
         $error("bit patterns must begin with a high slot");
      end
      if (ZERO_PAT[0] || ONE_PAT[0]) begin : g_bad_tail
         $error("bit patterns must end with a low slot");
      end
   endgenerate

   enc_state_t state_q;
   logic       last_q;
   logic       under_q;

   logic tick;
   logic shift_bit;
   logic at_end;
   logic lat_done;
   logic byte_end;
   logic accept;
   logic load;

   led_slot_divider #(.CLK_DIV(CLK_DIV)) u_div (
      .clk  (clk),
      .rst  (rst),
      .run  (state_q == ST_SEND),
      .tick (tick)
   );

   led_bit_shifter #(.ZERO_PAT(ZERO_PAT), .ONE_PAT(ONE_PAT)) u_shift (
      .clk         (clk),
      .rst         (rst),
      .load        (load),
      .load_byte   (in_data),
      .tick        (tick),
      .bit_out     (shift_bit),
      .at_byte_end (at_end)
   );

   led_latch_timer #(.LATCH_CYC(LATCH_CYC)) u_latch (
      .clk  (clk),
      .rst  (rst),
      .run  (state_q == ST_LATCH),
      .done (lat_done)
   );

   assign byte_end = tick && at_end;
   assign in_ready = (state_q == ST_IDLE) ||
                     ((state_q == ST_SEND) && byte_end && !last_q);
   assign accept   = in_valid && in_ready;
   assign load     = accept && ((state_q == ST_SEND) || in_first);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         last_q  <= 1'b0;
         under_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (load) begin
                  state_q <= ST_SEND;
                  last_q  <= in_last;
                  under_q <= 1'b0;
               end
            end
            ST_SEND: begin
               if (byte_end) begin
                  if (last_q) begin
                     state_q <= ST_LATCH;
                  end else if (in_valid) begin
                     last_q <= in_last;
                  end else begin
                     under_q <= 1'b1;
                     state_q <= ST_LATCH;
                  end
               end
            end
            ST_LATCH: begin
               if (lat_done) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign line_out = (state_q == ST_SEND) && shift_bit;
   assign busy     = (state_q != ST_IDLE);
   assign underrun = under_q;

   assert_stray_byte_dropped_R2: assert property (@(posedge clk) disable iff (rst)
      ((state_q == ST_IDLE) && in_valid && !in_first) |=> !busy);

   assert_no_gap_R5: assert property (@(posedge clk) disable iff (rst)
      ((state_q == ST_SEND) && load) |=> line_out);

   assert_idle_after_latch_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(lat_done));

   assert_underrun_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(underrun) |-> $past(byte_end));

endmodule

// File: tb/led_chain_encoder_tb_top.sv
module led_chain_encoder_tb_top;

   localparam int D      = 3;
   localparam int LSLOTS = 10;
   localparam int LATCH  = D * LSLOTS;
   localparam int BYTE_CYC = 64 * D;

   logic       clk = 1'b0;
   logic       rst;
   logic       in_valid;
   logic [7:0] in_data;
   logic       in_first;
   logic       in_last;
   logic       in_ready;
   logic       line_out;
   logic       busy;
   logic       underrun;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   led_chain_encoder #(.CLK_DIV(D), .LATCH_SLOTS(LSLOTS)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_first (in_first),
      .in_last  (in_last),
      .in_ready (in_ready),
      .line_out (line_out),
      .busy     (busy),
      .underrun (underrun)
   );

   typedef struct {
      logic [7:0] d;
      logic       f;
      logic       l;
   } item_t;

   item_t      src_q[$];
   logic [7:0] exp_q[$];

   // reference model: 0 idle, 1 sending, 2 latching
   int         m_st    = 0;
   int         m_pos   = 0;
   int         m_lat   = 0;
   logic [7:0] m_byte  = 8'h00;
   logic       m_last  = 1'b0;
   logic       m_under = 1'b0;
   int         acc_cnt = 0;
   int         pop_cnt = 0;

   function automatic logic m_ready();
      return (m_st == 0) || (m_st == 1 && m_pos == BYTE_CYC - 1 && !m_last);
   endfunction

   function automatic logic m_line();
      int slot;
      int bitn;
      if (m_st != 1) return 1'b0;
      slot = (m_pos / D) % 8;
      bitn = 7 - m_pos / (8 * D);
      return (slot < 2) || (slot < 4 && m_byte[bitn]);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_st = 0; m_pos = 0; m_lat = 0; m_last = 1'b0; m_under = 1'b0;
      end else begin
         logic r;
         logic acc;
         r   = m_ready();
         acc = in_valid && r;
         if (acc) acc_cnt++;
         case (m_st)
            0: if (acc && in_first) begin
                  m_byte = in_data; m_last = in_last; m_pos = 0;
                  m_st = 1; m_under = 1'b0; exp_q.push_back(in_data);
               end
            1: if (m_pos == BYTE_CYC - 1) begin
                  if (m_last) begin
                     m_st = 2; m_lat = 0;
                  end else if (acc) begin
                     m_byte = in_data; m_last = in_last; m_pos = 0;
                     exp_q.push_back(in_data);
                  end else begin
                     m_under = 1'b1; m_st = 2; m_lat = 0;
                  end
               end else begin
                  m_pos++;
               end
            default: if (m_lat == LATCH - 1) m_st = 0; else m_lat++;
         endcase
      end
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // pulse-width decoder: rebuilds bytes from the line
   int         hi_len = 0;
   int         nbits  = 0;
   logic [7:0] acc_byte = 8'h00;

   task automatic decode();
      if (line_out) begin
         hi_len++;
      end else if (hi_len > 0) begin
         acc_byte = {acc_byte[6:0], (hi_len > 3 * D)};
         chk(hi_len == 2 * D || hi_len == 4 * D, "R3", "high pulse width", hi_len, 2 * D);
         hi_len = 0;
         nbits++;
         if (nbits == 8) begin
            logic [7:0] e;
            nbits = 0;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
            chk(acc_byte === e, "R4/R6", "decoded byte", acc_byte, e);
         end
      end
   endtask

   task automatic step();
      @(negedge clk);
      chk(line_out === m_line(), "R3", "line_out", line_out, m_line());
      chk(in_ready === m_ready(), (m_st == 2) ? "R7" : "R5", "in_ready", in_ready, m_ready());
      chk(busy === (m_st != 0), "R9", "busy", busy, m_st != 0);
      chk(underrun === m_under, "R8", "underrun", underrun, m_under);
      decode();
      while (pop_cnt < acc_cnt) begin
         void'(src_q.pop_front());
         pop_cnt++;
      end
      if (src_q.size() > 0) begin
         in_valid = 1'b1;
         in_data  = src_q[0].d;
         in_first = src_q[0].f;
         in_last  = src_q[0].l;
      end else begin
         in_valid = 1'b0;
         in_data  = 8'h00;
         in_first = 1'b0;
         in_last  = 1'b0;
      end
   endtask

   task automatic run_idle();
      int guard = 0;
      do begin
         step();
         guard++;
      end while (!(src_q.size() == 0 && m_st == 0) && guard < 20000);
      repeat (3) step();
   endtask

   task automatic push(input logic [7:0] d, input logic f, input logic l);
      item_t it;
      it.d = d; it.f = f; it.l = l;
      src_q.push_back(it);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_data = 8'h00; in_first = 1'b0; in_last = 1'b0;
      repeat (3) @(negedge clk);
      chk(line_out === 1'b0, "R1", "reset line_out", line_out, 0);
      chk(busy === 1'b0, "R1", "reset busy", busy, 0);
      chk(underrun === 1'b0, "R1", "reset underrun", underrun, 0);
      chk(in_ready === 1'b1, "R1", "reset in_ready", in_ready, 1);
      rst = 1'b0;

      // R2: stray byte without start marker
      push(8'hFF, 1'b0, 1'b0);
      repeat (5) step();
      chk(busy === 1'b0, "R2", "busy after stray byte", busy, 0);
      chk(line_out === 1'b0, "R2", "line after stray byte", line_out, 0);

      // two LEDs, mid-frame start marker on byte 3 (R6)
      push(8'h00, 1'b1, 1'b0);
      push(8'hFF, 1'b0, 1'b0);
      push(8'hA5, 1'b0, 1'b0);
      push(8'h3C, 1'b1, 1'b0);
      push(8'h81, 1'b0, 1'b0);
      push(8'h7E, 1'b0, 1'b1);
      run_idle();

      // single-byte frame
      push(8'h5A, 1'b1, 1'b1);
      run_idle();

      // starved frame (R8)
      push(8'hC3, 1'b1, 1'b0);
      push(8'h18, 1'b0, 1'b0);
      run_idle();
      chk(underrun === 1'b1, "R8", "flag held after starved frame", underrun, 1);

      // two frames queued back to back: second waits out the latch (R7)
      push(8'h12, 1'b1, 1'b0);
      push(8'h34, 1'b0, 1'b0);
      push(8'h56, 1'b0, 1'b1);
      push(8'h9F, 1'b1, 1'b0);
      push(8'h60, 1'b0, 1'b1);
      run_idle();
      chk(underrun === 1'b0, "R8", "flag cleared by new frame", underrun, 0);
      chk(exp_q.size() == 0, "R4", "bytes left undecoded", exp_q.size(), 0);
      chk(busy === 1'b0 && in_ready === 1'b1, "R7", "idle after latch", busy, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule